// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block sequences an external successive-approximation converter on behalf of a processor core. Software sees two byte-wide registers: a control register (address 0) holding the module enable, a sticky completion flag, a start/busy bit, a 3-bit channel field and a 2-bit conversion-clock select, and a read-only result register (address 1). When software sets the start/busy bit with the module enabled, the block latches the channel onto the analog mux select. It then raises the converter start line for a fixed number of conversion-clock periods, pulsing a clock enable once per period. After that it waits for the converter's done pulse, captures the data, clears the start/busy bit and raises the completion flag.

The conversion clock comes either from a divide-by-32 of the system clock or from a free-running internal clock input. The internal clock input is synchronised and its rising edges are used. The core's sleep state is an input. A conversion runs on through sleep only when the internal clock is selected and the converter interrupt is enabled, and its completion then raises a wake request. In every other case, entering sleep aborts the conversion. Clearing the enable bit during a conversion also aborts it.

Top module: `adc_seq`

## Requirements
- R1: After reset the control register reads 0x00, the result register reads 0x00, and conv_start_o, conv_clk_en_o, irq_o and wake_o are low.
- R2: Control bit layout: [7:6] clock select, [5:3] channel, [2] start/busy, [1] completion flag, [0] enable. A write with bit 2 = 1 and bit 0 = 1 while idle starts a conversion, and bit 2 reads 1 until the conversion ends. A write with bit 2 = 1 and bit 0 = 0 starts nothing, and bit 2 reads 0.
- R3: chan_sel_o takes the channel field of the starting write and holds it for the whole conversion. A channel write during a conversion is stored in the register but reaches chan_sel_o only at the next start.
- R4: conv_start_o stays high for exactly 10 conv_clk_en_o pulses and then drops. conv_clk_en_o pulses only while conv_start_o is high.
- R5: A conv_done_i pulse after conv_start_o has dropped loads conv_data_i into the result register, clears bit 2 and sets bit 1. Otherwise the result register does not change.
- R6: The completion flag stays set until software writes 0 to bit 1. irq_o is high while the flag is set and irq_en_i is high.
- R7: With clock select 11, conv_clk_en_o pulses follow the rising edges of conv_rc_clk_i. With any other value, they come every 32 system clocks.
- R8: If sleep_i is high during a conversion while clock select is not 11 or irq_en_i is low, the conversion aborts. conv_start_o drops, bit 2 clears, the flag stays clear, the result is unchanged, and bit 0 still reads 1.
- R9: With clock select 11 and irq_en_i high, a conversion completes normally in sleep. wake_o is then high while the flag, irq_en_i and sleep_i are all high.
- R10: Writing bit 0 = 0 during a conversion aborts it: bit 2 clears and the flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control, 1 result |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| irq_en_i | input | 1 | Converter interrupt enabled by the core |
| sleep_i | input | 1 | Core is in sleep |
| conv_rc_clk_i | input | 1 | Free-running internal conversion clock |
| chan_sel_o | output | 3 | Analog mux channel select |
| conv_start_o | output | 1 | Converter start line |
| conv_clk_en_o | output | 1 | One pulse per conversion-clock period |
| conv_done_i | input | 1 | Converter done pulse |
| conv_data_i | input | 8 | Converter result data |
| irq_o | output | 1 | Completion interrupt request |
| wake_o | output | 1 | Wake request to the sleeping core |

## Verification
Random conversions draw the clock select, channel, data value and interrupt enable. The enable pulse count shows whether the start phase has the correct length. The measured enable spacing shows which clock source was used. The captured result and the flag show whether the done handshake was honoured. Directed cases cover the following:
- a start with the module disabled;
- a channel write during a busy conversion, which must not move the mux;
- flag clearing;
- sleep entry under both abort conditions, which must leave the result and the flag untouched;
- the one sleep configuration that must complete and raise a wake request;
- disabling the module mid-conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_WAIT} seq_state_e;
  localparam int BIT_EN   = 0;
  localparam int BIT_FLAG = 1;
  localparam int BIT_GO   = 2;
  localparam int CH_LO    = 3;
  localparam int SEL_LO   = 6;
  localparam logic [1:0] SEL_INT = 2'b11;
endpackage

// File: rtl/adc_seq_clkgen.sv
module adc_seq_clkgen #(
  parameter int DIV         = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rc_clk_i,
  input  logic sel_int_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] div_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic rc_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else if (div_q == CW'(DIV - 1)) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else sync_q[0] <= rc_clk_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rc_prev_q <= 1'b0;
    else rc_prev_q <= sync_q[SYNC_STAGES-1];
  end

  logic rc_tick, div_tick;
  assign rc_tick  = sync_q[SYNC_STAGES-1] & ~rc_prev_q;
  assign div_tick = (div_q == CW'(DIV - 1));
  assign tick_o   = sel_int_i ? rc_tick : div_tick;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CONV_TICKS = 10,
  parameter int CH_W       = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            abort_i,
  input  logic            tick_i,
  input  logic            done_i,
  output logic            busy_o,
  output logic            complete_o,
  output logic            conv_start_o,
  output logic            clk_en_o,
  output logic [CH_W-1:0] chan_o
);
  localparam int TW = $clog2(CONV_TICKS + 1);

  seq_state_e    state_q;
  logic [TW-1:0] cnt_q;
  logic [CH_W-1:0] chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      chan_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CONV;
          cnt_q   <= '0;
          chan_q  <= chan_i;
        end
        ST_CONV: begin
          if (abort_i) state_q <= ST_IDLE;
          else if (tick_i) begin
            if (cnt_q == TW'(CONV_TICKS - 1)) state_q <= ST_WAIT;
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT: if (abort_i || done_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign conv_start_o = (state_q == ST_CONV);
  assign clk_en_o     = (state_q == ST_CONV) & tick_i;
  assign complete_o   = (state_q == ST_WAIT) & done_i & ~abort_i;
  assign chan_o       = chan_q;
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              busy_i,
  input  logic              complete_i,
  input  logic              abort_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              start_o,
  output logic [2:0]        start_chan_o,
  output logic [1:0]        sel_o,
  output logic              en_o,
  output logic              flag_o,
  output logic              go_o,
  output logic [DATA_W-1:0] result_o,
  output logic [7:0]        rdata_o
);
  logic [1:0] sel_q;
  logic [2:0] chan_q;
  logic go_q, flag_q, en_q;
  logic [DATA_W-1:0] res_q;
  logic wr_ctrl;

  assign wr_ctrl      = wr_i & ~addr_i;
  assign start_o      = wr_ctrl & wdata_i[BIT_GO] & wdata_i[BIT_EN] & ~busy_i;
  assign start_chan_o = wdata_i[CH_LO +: 3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      chan_q <= '0;
      go_q   <= 1'b0;
      flag_q <= 1'b0;
      en_q   <= 1'b0;
      res_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        sel_q  <= wdata_i[SEL_LO +: 2];
        chan_q <= wdata_i[CH_LO +: 3];
        en_q   <= wdata_i[BIT_EN];
        flag_q <= wdata_i[BIT_FLAG];
        if (!busy_i) go_q <= wdata_i[BIT_GO] & wdata_i[BIT_EN];
      end
      if (complete_i) begin
        res_q  <= conv_data_i;
        flag_q <= 1'b1;
        go_q   <= 1'b0;
      end else if (abort_i) begin
        go_q <= 1'b0;
      end
    end
  end

  assign sel_o    = sel_q;
  assign en_o     = en_q;
  assign flag_o   = flag_q;
  assign go_o     = go_q;
  assign result_o = res_q;
  assign rdata_o  = addr_i ? 8'(res_q) : {sel_q, chan_q, go_q, flag_q, en_q};
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DIV        = 32,
  parameter int CONV_TICKS = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              irq_en_i,
  input  logic              sleep_i,
  input  logic              conv_rc_clk_i,
  output logic [2:0]        chan_sel_o,
  output logic              conv_start_o,
  output logic              conv_clk_en_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              irq_o,
  output logic              wake_o
);
  logic start, busy, complete, abort, tick, en, flag, go;
  logic [2:0] start_chan;
  logic [1:0] sel;
  logic [DATA_W-1:0] result;
  logic sleep_ok;

  // sleep keeps a conversion alive only on internal clock with interrupt enabled
  assign sleep_ok = (sel == SEL_INT) & irq_en_i;
  assign abort    = busy & (~en | (sleep_i & ~sleep_ok));

  adc_seq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(wr_en_i), .addr_i, .wdata_i,
    .busy_i(busy), .complete_i(complete), .abort_i(abort),
    .conv_data_i,
    .start_o(start), .start_chan_o(start_chan), .sel_o(sel),
    .en_o(en), .flag_o(flag), .go_o(go), .result_o(result),
    .rdata_o
  );

  adc_seq_clkgen #(.DIV(DIV), .SYNC_STAGES(2)) u_clkgen (
    .clk_i, .rst_ni,
    .rc_clk_i(conv_rc_clk_i), .sel_int_i(sel == SEL_INT),
    .tick_o(tick)
  );

  adc_seq_fsm #(.CONV_TICKS(CONV_TICKS), .CH_W(3)) u_fsm (
    .clk_i, .rst_ni,
    .start_i(start), .chan_i(start_chan), .abort_i(abort),
    .tick_i(tick), .done_i(conv_done_i),
    .busy_o(busy), .complete_o(complete),
    .conv_start_o, .clk_en_o(conv_clk_en_o), .chan_o(chan_sel_o)
  );

  assign irq_o  = flag & irq_en_i;
  assign wake_o = flag & irq_en_i & sleep_i;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sleep_i,
  input logic              irq_en_i,
  input logic              conv_start_o,
  input logic              conv_clk_en_o,
  input logic [2:0]        chan_sel_o,
  input logic              wake_o,
  input logic              go_i,
  input logic [1:0]        sel_i,
  input logic [DATA_W-1:0] result_i,
  input logic              complete_i,
  input logic              busy_i
);
  a_r4_clk_en_in_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_clk_en_o |-> conv_start_o);

  a_r2_go_while_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> go_i);

  a_r5_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !complete_i |=> $stable(result_i));

  a_r8_sleep_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && sleep_i && !(sel_i == 2'b11 && irq_en_i)) |=> !busy_i);

  a_r3_chan_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(chan_sel_o));

  a_r9_wake_in_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> sleep_i);
endmodule

bind adc_seq adc_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .irq_en_i(irq_en_i),
  .conv_start_o(conv_start_o), .conv_clk_en_o(conv_clk_en_o),
  .chan_sel_o(chan_sel_o), .wake_o(wake_o), .go_i(go), .sel_i(sel),
  .result_i(result), .complete_i(complete), .busy_i(busy)
);

// File: tb/adc_seq_bench.sv
`timescale 1ns/1ps
module adc_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic irq_en = 1'b0, sleep = 1'b0, rc_clk = 1'b0;
  logic [2:0] chan_sel;
  logic conv_start, conv_clk_en, conv_done = 1'b0;
  logic [7:0] conv_data = '0;
  logic irq, wake;

  int n_tests = 0, n_fail = 0;
  int ticks = 0, gap = 0, last_tick = 0, cyc = 0, pend = 0;
  logic prev_start = 1'b0;
  int done_delay = 2;
  bit finished = 0;

  adc_seq u_adc_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_en_i(irq_en), .sleep_i(sleep), .conv_rc_clk_i(rc_clk),
    .chan_sel_o(chan_sel), .conv_start_o(conv_start), .conv_clk_en_o(conv_clk_en),
    .conv_done_i(conv_done), .conv_data_i(conv_data), .irq_o(irq), .wake_o(wake)
  );

  always #4 clk = ~clk;
  initial begin #2; forever #40 rc_clk = ~rc_clk; end

  // behavioural converter
  always @(negedge clk) begin
    cyc++;
    conv_done = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) conv_done = 1'b1;
    end
    if (conv_start && !prev_start) ticks = 0;
    if (conv_start && conv_clk_en) begin
      ticks++;
      gap = cyc - last_tick;
      last_tick = cyc;
    end
    if (prev_start && !conv_start) pend = done_delay;
    prev_start = conv_start;
  end

  function automatic int exp_gap(input logic [1:0] sel);
    return (sel == 2'b11) ? 10 : 32;
  endfunction

  function automatic logic [7:0] ctrl_word(input logic [1:0] sel, input logic [2:0] ch,
                                           input logic go, input logic fl, input logic en);
    return {sel, ch, go, fl, en};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0;
  endtask

  function automatic logic [7:0] rd_result();
    return 8'h00;
  endfunction

  task automatic read_res(output logic [7:0] v);
    addr = 1'b1; #1; v = rdata; addr = 1'b0; #1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (!rdata[2]) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic conv_run(input logic [1:0] sel, input logic [2:0] ch, input logic [7:0] d);
    logic [7:0] r;
    conv_data = d;
    wr(1'b0, ctrl_word(sel, ch, 1'b1, 1'b0, 1'b1));
    check("R2 busy bit", rdata[2], 1);
    check("R3 chan latched", chan_sel, ch);
    wait_idle();
    check("R4 enable pulses", ticks, 10);
    check("R7 enable spacing", gap, exp_gap(sel));
    read_res(r);
    check("R5 result", r, d);
    check("R5 flag set", rdata[1], 1);
    check("R6 irq", irq, irq_en);
  endtask

  initial begin
    logic [7:0] r;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctrl reset", rdata, 0);
    read_res(r);
    check("R1 result reset", r, 0);
    check("R1 outputs low", {conv_start, conv_clk_en, irq, wake}, 0);

    // R2 start with module disabled
    wr(1'b0, ctrl_word(2'b00, 3'd1, 1'b1, 1'b0, 1'b0));
    repeat (40) @(negedge clk);
    check("R2 no start when disabled", rdata[2], 0);
    check("R2 start line idle", conv_start, 0);

    // random conversions
    for (int k = 0; k < 16; k++) begin
      logic [1:0] s;
      logic [2:0] c;
      logic [7:0] d;
      s = 2'($urandom % 4); c = 3'($urandom % 8); d = 8'($urandom % 256);
      irq_en = 1'($urandom % 2);
      done_delay = 1 + int'($urandom % 4);
      conv_run(s, c, d);
    end

    // R6 flag sticky, cleared by writing 0
    irq_en = 1'b1;
    conv_run(2'b01, 3'd6, 8'hA5);
    repeat (20) @(negedge clk);
    check("R6 flag sticky", rdata[1], 1);
    check("R6 irq while flag", irq, 1);
    wr(1'b0, ctrl_word(2'b01, 3'd6, 1'b0, 1'b0, 1'b1));
    check("R6 flag cleared", rdata[1], 0);
    check("R6 irq cleared", irq, 0);

    // R3 channel write during busy
    conv_data = 8'h3C;
    wr(1'b0, ctrl_word(2'b00, 3'd2, 1'b1, 1'b0, 1'b1));
    repeat (50) @(negedge clk);
    wr(1'b0, ctrl_word(2'b00, 3'd5, 1'b1, 1'b0, 1'b1));
    check("R3 chan field stored", rdata[5:3], 5);
    check("R3 mux unchanged", chan_sel, 2);
    check("R3 still busy", rdata[2], 1);
    wait_idle();
    read_res(r);
    check("R3 busy conv result", r, 8'h3C);
    conv_run(2'b00, 3'd5, 8'h5A);

    // R8 sleep abort, divider clock
    irq_en = 1'b1;
    conv_data = 8'hEE;
    wr(1'b0, ctrl_word(2'b10, 3'd3, 1'b1, 1'b0, 1'b1));
    repeat (60) @(negedge clk);
    sleep = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 start dropped", conv_start, 0);
    check("R8 busy cleared", rdata[2], 0);
    check("R8 enable kept", rdata[0], 1);
    repeat (10) @(negedge clk);
    check("R8 flag clear", rdata[1], 0);
    read_res(r);
    check("R8 result unchanged", r, 8'h5A);
    sleep = 1'b0;

    // R8 sleep abort, internal clock but interrupt disabled
    irq_en = 1'b0;
    wr(1'b0, ctrl_word(2'b11, 3'd4, 1'b1, 1'b0, 1'b1));
    repeat (25) @(negedge clk);
    sleep = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 abort no irq busy", rdata[2], 0);
    repeat (10) @(negedge clk);
    check("R8 abort no irq flag", rdata[1], 0);
    read_res(r);
    check("R8 abort no irq result", r, 8'h5A);
    sleep = 1'b0;

    // R9 conversion completes in sleep
    irq_en = 1'b1;
    conv_data = 8'h77;
    wr(1'b0, ctrl_word(2'b11, 3'd7, 1'b1, 1'b0, 1'b1));
    repeat (5) @(negedge clk);
    check("R9 wake low before done", wake, 0);
    sleep = 1'b1;
    wait_idle();
    check("R9 ticks in sleep", ticks, 10);
    read_res(r);
    check("R9 result in sleep", r, 8'h77);
    check("R9 wake", wake, 1);
    sleep = 1'b0;
    @(negedge clk);
    check("R9 wake follows sleep", wake, 0);
    wr(1'b0, ctrl_word(2'b11, 3'd7, 1'b0, 1'b0, 1'b1));

    // R10 disable during conversion
    conv_data = 8'h11;
    wr(1'b0, ctrl_word(2'b00, 3'd1, 1'b1, 1'b0, 1'b1));
    repeat (40) @(negedge clk);
    wr(1'b0, ctrl_word(2'b00, 3'd1, 1'b1, 1'b0, 1'b0));
    @(negedge clk);
    check("R10 busy cleared", rdata[2], 0);
    check("R10 start dropped", conv_start, 0);
    repeat (10) @(negedge clk);
    check("R10 flag clear", rdata[1], 0);
    read_res(r);
    check("R10 result unchanged", r, 8'h77);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule